// File: doc/BRIEF.md
# Processor Status Register with ALU Flags

This block is the 8-bit status word of a small accumulator-style processor core. It keeps three ALU condition flags (zero, nibble carry, carry), two power-state bits that report why the core last woke or stopped, and three bank-select bits that extend short data addresses. Each clock it can take a bus write from the core, a flag update from the current ALU operation, and single-cycle event strobes from the watchdog and sleep logic. It merges these by fixed rules into the next register value.

The flag logic works from the ALU operands and an operation code. It produces zero, a carry out of bit 3 and a carry out of bit 7 for addition, and the same flags with inverted-borrow meaning for subtraction. Rotate-through-carry operations and a clear operation update only some of the flags. The bank bits form two 9-bit data-memory addresses: a direct one from a 7-bit instruction offset and an indirect one from an 8-bit pointer. Both are presented combinationally.

Top module: `cpu_status_reg`

## Requirements
- R1: `status_o` presents the register with bit 7 = indirect bank, bit 6 = bank high, bit 5 = bank low, bit 4 = time-out flag (TMO), bit 3 = power-down flag (PWD), bit 2 = zero, bit 1 = nibble carry, bit 0 = carry. Every update is visible on `status_o` one clock after the inputs that cause it.
- R2: While `rst` is high at a clock edge, bits 7..5 clear to 0 and bits 4..3 set to 1. Bits 2..0 keep their prior value.
- R3: When `flag_en_i` is high, a bus write in the same cycle does not change bits 2..0. Flags that the operation updates take the flag-logic value, and the other flags hold.
- R4: Bits 4..3 never take bus write data. Only events and reset change them.
- R5: A bus write of 0x00 with all mask bits set, in the same cycle as `flag_en_i` with the clear operation (`alu_op_i`=5), gives 000u u1uu: bits 7..5 are 0, bit 2 is 1, and bits 4,3,1,0 are unchanged.
- R6: A watchdog time-out clears TMO and leaves PWD unchanged. A sleep event sets TMO and clears PWD. A watchdog-clear event sets both.
- R7: When several events come in the same cycle, only the highest-priority one acts. The order from highest is reset, then time-out, then sleep, then watchdog clear.
- R8: Addition (`alu_op_i`=0) sets carry when a+b > 255, nibble carry when a[3:0]+b[3:0] > 15, and zero when (a+b) mod 256 = 0.
- R9: Subtraction (`alu_op_i`=1, computes a−b) sets carry when a >= b, nibble carry when a[3:0] >= b[3:0], and zero when a = b.
- R10: Rotate right (`alu_op_i`=3) loads carry with a[0], and rotate left (`alu_op_i`=4) loads carry with a[7]. Zero and nibble carry hold. A logic operation (`alu_op_i`=2) updates only zero, set when `alu_a_i`=0.
- R11: Without `flag_en_i`, a bus write changes exactly the writable bits (7..5 and 2..0) whose `wr_mask_i` bit is 1. Other bits hold.
- R12: `dir_addr_o` = {bit 6, bit 5, `dir_ofs_i`} and `ind_addr_o` = {bit 7, `ind_ptr_i`}, both combinational from the current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en_i | input | 1 | Bus write to the status register |
| wr_data_i | input | 8 | Bus write data |
| wr_mask_i | input | 8 | Per-bit write enable (bit operations use one bit) |
| flag_en_i | input | 1 | Current instruction updates flags |
| alu_op_i | input | 3 | Flag operation: 0 add, 1 sub, 2 logic, 3 rotate right, 4 rotate left, 5 clear |
| alu_a_i | input | 8 | First ALU operand (the result for logic ops) |
| alu_b_i | input | 8 | Second ALU operand |
| wdt_clr_i | input | 1 | Watchdog-clear event strobe |
| sleep_i | input | 1 | Sleep-entry event strobe |
| wdt_tmo_i | input | 1 | Watchdog time-out event strobe |
| dir_ofs_i | input | 7 | Direct address offset from the instruction |
| ind_ptr_i | input | 8 | Indirect address pointer |
| status_o | output | 8 | Status register value |
| dir_addr_o | output | 9 | Banked direct data address |
| ind_addr_o | output | 9 | Banked indirect data address |

## Verification
The hardest case to reach is a cycle where a bus write, a flag update and one or more power events all land together. In that cycle each field must follow a different rule: banks from the bus, flags from the ALU, power bits from the winning event. Random stimulus raises writes and flag updates often and each event strobe about one cycle in six, so such collisions occur many times. Directed cases then force the clear-register pattern, every event pair, and nibble and byte carry boundaries such as 0x0F+0x01, 0xFF+0x01 and equal-operand subtraction.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

    localparam int STAT_W = 8;

    typedef struct packed {
        logic ibank;
        logic bank_hi;
        logic bank_lo;
        logic tmo;
        logic pwd;
        logic z;
        logic dc;
        logic c;
    } status_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_LOG  = 3'd2,
        OP_ROTR = 3'd3,
        OP_ROTL = 3'd4,
        OP_CLR  = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic       z;
        logic       dc;
        logic       c;
        logic [2:0] upd;   // {z, dc, c} update enables
    } flag_res_t;

    typedef struct packed {
        logic tmo;
        logic pwd;
    } pwr_bits_t;

    // bits that a bus write may touch
    localparam logic [STAT_W-1:0] BUS_WR_MASK = 8'b1110_0111;
    localparam logic [STAT_W-1:0] FLAG_MASK   = 8'b0000_0111;

    function automatic logic [4:0] nib_sum(input logic [3:0] x,
                                           input logic [3:0] y,
                                           input logic       cin);
        return {1'b0, x} + {1'b0, y} + {4'd0, cin};
    endfunction

endpackage

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import cpu_status_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output flag_res_t     res_o
);
    localparam int NIB = 4;

    logic [DW:0]    sum;
    logic [DW-1:0]  opb;
    logic           cin;
    logic [NIB:0]   lo_sum;

    always_comb begin
        opb    = (op_i == OP_SUB) ? ~b_i : b_i;
        cin    = (op_i == OP_SUB);
        sum    = {1'b0, a_i} + {1'b0, opb} + {{DW{1'b0}}, cin};
        lo_sum = nib_sum(a_i[NIB-1:0], opb[NIB-1:0], cin);
        res_o  = '0;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                res_o.z   = (sum[DW-1:0] == '0);
                res_o.dc  = lo_sum[NIB];
                res_o.c   = sum[DW];
                res_o.upd = 3'b111;
            end
            OP_LOG: begin
                res_o.z   = (a_i == '0);
                res_o.upd = 3'b100;
            end
            OP_ROTR: begin
                res_o.c   = a_i[0];
                res_o.upd = 3'b001;
            end
            OP_ROTL: begin
                res_o.c   = a_i[DW-1];
                res_o.upd = 3'b001;
            end
            OP_CLR: begin
                res_o.z   = 1'b1;
                res_o.upd = 3'b100;
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/status_event_ctrl.sv
module status_event_ctrl
    import cpu_status_pkg::*;
(
    input  logic      tmo_evt_i,
    input  logic      sleep_evt_i,
    input  logic      clr_evt_i,
    input  pwr_bits_t cur_i,
    output pwr_bits_t nxt_o
);
    typedef enum logic [1:0] {EV_NONE, EV_TMO, EV_SLEEP, EV_CLR} ev_e;
    ev_e win;

    always_comb begin
        if (tmo_evt_i)        win = EV_TMO;
        else if (sleep_evt_i) win = EV_SLEEP;
        else if (clr_evt_i)   win = EV_CLR;
        else                  win = EV_NONE;

        nxt_o = cur_i;
        unique case (win)
            EV_TMO:   nxt_o.tmo = 1'b0;
            EV_SLEEP: begin nxt_o.tmo = 1'b1; nxt_o.pwd = 1'b0; end
            EV_CLR:   begin nxt_o.tmo = 1'b1; nxt_o.pwd = 1'b1; end
            default:  nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/status_bank_addr.sv
module status_bank_addr #(
    parameter int OFS_W = 7,
    parameter int PTR_W = 8,
    localparam int DA_W = OFS_W + 2,
    localparam int IA_W = PTR_W + 1
) (
    input  logic [1:0]       bank_i,
    input  logic             ibank_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [DA_W-1:0]  dir_o,
    output logic [IA_W-1:0]  ind_o
);
    assign dir_o = {bank_i, ofs_i};
    assign ind_o = {ibank_i, ptr_i};
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import cpu_status_pkg::*;
#(
    parameter int DIR_OFS_W = 7,
    parameter int PTR_W     = 8,
    localparam int DA_W = DIR_OFS_W + 2,
    localparam int IA_W = PTR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [STAT_W-1:0]    wr_data_i,
    input  logic [STAT_W-1:0]    wr_mask_i,
    input  logic                 flag_en_i,
    input  logic [2:0]           alu_op_i,
    input  logic [STAT_W-1:0]    alu_a_i,
    input  logic [STAT_W-1:0]    alu_b_i,
    input  logic                 wdt_clr_i,
    input  logic                 sleep_i,
    input  logic                 wdt_tmo_i,
    input  logic [DIR_OFS_W-1:0] dir_ofs_i,
    input  logic [PTR_W-1:0]     ind_ptr_i,
    output logic [STAT_W-1:0]    status_o,
    output logic [DA_W-1:0]      dir_addr_o,
    output logic [IA_W-1:0]      ind_addr_o
);
    status_t   st_q, st_d;
    flag_res_t fres;
    pwr_bits_t pwr_nxt;
    logic [STAT_W-1:0] wr_sel, merged;

    status_flag_unit #(.DW(STAT_W)) flag_u (
        .op_i (alu_op_i),
        .a_i  (alu_a_i),
        .b_i  (alu_b_i),
        .res_o(fres)
    );

    status_event_ctrl evt_u (
        .tmo_evt_i  (wdt_tmo_i),
        .sleep_evt_i(sleep_i),
        .clr_evt_i  (wdt_clr_i),
        .cur_i      ('{tmo: st_q.tmo, pwd: st_q.pwd}),
        .nxt_o      (pwr_nxt)
    );

    status_bank_addr #(.OFS_W(DIR_OFS_W), .PTR_W(PTR_W)) addr_u (
        .bank_i (st_q[6:5]),
        .ibank_i(st_q.ibank),
        .ofs_i  (dir_ofs_i),
        .ptr_i  (ind_ptr_i),
        .dir_o  (dir_addr_o),
        .ind_o  (ind_addr_o)
    );

    always_comb begin
        wr_sel = wr_en_i ? (wr_mask_i & BUS_WR_MASK) : '0;
        if (flag_en_i) wr_sel = wr_sel & ~FLAG_MASK;
        merged = (st_q & ~wr_sel) | (wr_data_i & wr_sel);
        st_d   = status_t'(merged);
        if (flag_en_i) begin
            if (fres.upd[2]) st_d.z  = fres.z;
            if (fres.upd[1]) st_d.dc = fres.dc;
            if (fres.upd[0]) st_d.c  = fres.c;
        end
        st_d.tmo = pwr_nxt.tmo;
        st_d.pwd = pwr_nxt.pwd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ibank   <= 1'b0;
            st_q.bank_hi <= 1'b0;
            st_q.bank_lo <= 1'b0;
            st_q.tmo     <= 1'b1;
            st_q.pwd     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q;

    // R2
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_o[7:5] == 3'b000 && status_o[4:3] == 2'b11));

    // R3
    flag_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en_i && wr_en_i && alu_op_i == 3'd5) |=> status_o[2]);

    // R4
    pwr_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wdt_clr_i && !sleep_i && !wdt_tmo_i) |=> $stable(status_o[4:3]));

    // R6
    tmo_evt_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_tmo_i |=> (!status_o[4] && status_o[3] == $past(status_o[3])));

    // R7
    sleep_over_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && !wdt_tmo_i) |=> (status_o[4] && !status_o[3]));

    // R8
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en_i && alu_op_i == 3'd0) |=>
            (status_o[0] == ($past({1'b0, alu_a_i}) + $past({1'b0, alu_b_i}) > 9'd255)));

    // R12
    always_comb begin
        dir_bank_chk: assert (dir_addr_o[DA_W-1 -: 2] == status_o[6:5]);
    end
endmodule

// File: tb/cpu_status_reg_tb_top.sv
module cpu_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en_i;
    logic [7:0] wr_data_i, wr_mask_i;
    logic       flag_en_i;
    logic [2:0] alu_op_i;
    logic [7:0] alu_a_i, alu_b_i;
    logic       wdt_clr_i, sleep_i, wdt_tmo_i;
    logic [6:0] dir_ofs_i;
    logic [7:0] ind_ptr_i;
    logic [7:0] status_o;
    logic [8:0] dir_addr_o, ind_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp;
    bit done = 0;

    always #2 clk = ~clk;

    cpu_status_reg dut_i (.*);

    function automatic logic [7:0] model_next(input logic [7:0] cur);
        logic [7:0] n = cur;
        logic [7:0] sel;
        if (rst) begin
            n[7:5] = 3'b000;
            n[4:3] = 2'b11;
            return n;
        end
        sel = wr_en_i ? (wr_mask_i & 8'hE7) : 8'h00;
        if (flag_en_i) sel[2:0] = 3'b000;
        for (int i = 0; i < 8; i++) if (sel[i]) n[i] = wr_data_i[i];
        if (flag_en_i) begin
            case (alu_op_i)
                3'd0: begin
                    n[0] = (int'(alu_a_i) + int'(alu_b_i)) > 255;
                    n[1] = (int'(alu_a_i[3:0]) + int'(alu_b_i[3:0])) > 15;
                    n[2] = ((int'(alu_a_i) + int'(alu_b_i)) % 256) == 0;
                end
                3'd1: begin
                    n[0] = alu_a_i >= alu_b_i;
                    n[1] = alu_a_i[3:0] >= alu_b_i[3:0];
                    n[2] = alu_a_i == alu_b_i;
                end
                3'd2: n[2] = (alu_a_i == 8'd0);
                3'd3: n[0] = alu_a_i[0];
                3'd4: n[0] = alu_a_i[7];
                3'd5: n[2] = 1'b1;
                default: ;
            endcase
        end
        if (wdt_tmo_i)      n[4] = 1'b0;
        else if (sleep_i)   begin n[4] = 1'b1; n[3] = 1'b0; end
        else if (wdt_clr_i) begin n[4] = 1'b1; n[3] = 1'b1; end
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic idle_inputs();
        rst = 0; wr_en_i = 0; wr_data_i = 0; wr_mask_i = 8'hFF; flag_en_i = 0;
        alu_op_i = 0; alu_a_i = 0; alu_b_i = 0;
        wdt_clr_i = 0; sleep_i = 0; wdt_tmo_i = 0;
        dir_ofs_i = 0; ind_ptr_i = 0;
    endtask

    // inputs already set at negedge: compute model, clock, compare
    task automatic step(input string req);
        exp = model_next(exp);
        @(posedge clk); #1;
        check(req, status_o, exp);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_write(input logic [7:0] d, input logic [7:0] m);
        wr_en_i = 1; wr_data_i = d; wr_mask_i = m;
    endtask

    task automatic do_flag(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        flag_en_i = 1; alu_op_i = op; alu_a_i = a; alu_b_i = b;
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        idle_inputs();
        exp = 8'h00;
        @(negedge clk);
        rst = 1;
        exp = model_next(exp);
        @(posedge clk); #1;
        check("R2 reset upper bits", status_o[7:3], exp[7:3]);
        @(negedge clk); idle_inputs();

        // make flags known
        do_write(8'h07, 8'hFF); step("R11 full write");
        do_write(8'hFF, 8'hFF); step("R4 power bits ignore write");
        do_write(8'h00, 8'h40); step("R11 single bit clear");
        do_write(8'hFF, 8'h01); step("R11 single bit set");

        // R5 clear-register pattern
        do_write(8'hE3, 8'hFF); step("R11 setup");
        do_write(8'h00, 8'hFF); do_flag(3'd5, 8'h00, 8'h00); step("R5 clear pattern");
        check("R5 top bits zero", status_o[7:5], 3'b000);
        check("R5 zero set", status_o[2], 1'b1);

        // R3 flags win over write
        do_write(8'h07, 8'hFF); do_flag(3'd0, 8'h10, 8'h20); step("R3 flag wins");
        check("R3 flags from add", status_o[2:0], 3'b000);

        // R8 add boundaries
        do_flag(3'd0, 8'h0F, 8'h01); step("R8 nibble carry");
        do_flag(3'd0, 8'hFF, 8'h01); step("R8 byte carry and zero");
        check("R8 0xFF+1 flags", status_o[2:0], 3'b111);

        // R9 subtraction
        do_flag(3'd1, 8'h42, 8'h42); step("R9 equal operands");
        check("R9 no borrow equal", status_o[2:0], 3'b111);
        do_flag(3'd1, 8'h10, 8'h01); step("R9 nibble borrow");
        check("R9 borrow bits", status_o[1:0], 2'b01);

        // R10 rotates and logic
        do_flag(3'd3, 8'h01, 8'h00); step("R10 rotate right carry");
        do_flag(3'd4, 8'h7F, 8'h00); step("R10 rotate left carry");
        do_flag(3'd2, 8'h00, 8'h00); step("R10 logic zero");

        // R6 / R7 events
        wdt_tmo_i = 1; step("R6 timeout");
        check("R6 timeout TMO", status_o[4], 1'b0);
        sleep_i = 1; step("R6 sleep");
        wdt_clr_i = 1; step("R6 watchdog clear");
        wdt_tmo_i = 1; sleep_i = 1; wdt_clr_i = 1; step("R7 timeout wins");
        check("R7 timeout over others", status_o[4:3], 2'b01);
        sleep_i = 1; wdt_clr_i = 1; step("R7 sleep over clear");
        check("R7 sleep over clear bits", status_o[4:3], 2'b10);
        rst = 1; wdt_tmo_i = 1; step("R7 reset over timeout");

        // R12 addresses
        do_write(8'hC0, 8'hE0); step("R11 bank set");
        dir_ofs_i = 7'h55; ind_ptr_i = 8'hAA; #1;
        check("R12 direct addr", dir_addr_o, {exp[6:5], 7'h55});
        check("R12 indirect addr", ind_addr_o, {exp[7], 8'hAA});

        // random phase
        for (int k = 0; k < 3000; k++) begin
            rst       = ($urandom % 300) == 0;
            wr_en_i   = $urandom % 2;
            wr_data_i = $urandom;
            wr_mask_i = ($urandom % 2) ? 8'hFF : (8'h01 << ($urandom % 8));
            flag_en_i = $urandom % 2;
            alu_op_i  = $urandom % 6;
            alu_a_i   = ($urandom % 8 == 0) ? 8'hFF : $urandom;
            alu_b_i   = ($urandom % 8 == 0) ? alu_a_i : $urandom;
            wdt_clr_i = ($urandom % 6) == 0;
            sleep_i   = ($urandom % 6) == 0;
            wdt_tmo_i = ($urandom % 6) == 0;
            dir_ofs_i = $urandom;
            ind_ptr_i = $urandom;
            #1;
            check("R12 random direct", dir_addr_o, {exp[6:5], dir_ofs_i});
            check("R12 random indirect", ind_addr_o, {exp[7], ind_ptr_i});
            step("R1 random merge");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule